// File: doc/BRIEF.md
# PCI Option ROM Target

This block is the bus target that serves a card's option ROM on a 32-bit PCI bus. It holds a 32-bit ROM base register and the memory-space enable bit. Once software has set both enables, any memory command whose address falls inside the 64 KB window named by the base register is claimed. Reads are answered from an external byte-wide ROM. Each read fetches four bytes, one after another, using a programmable number of wait clocks per byte. The bytes are packed into a 32-bit holding word, and TRDY is asserted only after that word is complete.

A read burst is cut short: the first data phase completes normally and the second is refused with STOP. Writes into the window are claimed and accepted, but they change nothing. The target keeps DEVSEL asserted until the master has released both FRAME and IRDY. It then drops DEVSEL, TRDY and STOP on the same edge and goes back to waiting for an address phase.

Top module: `optrom_target`

## Requirements
- R1: After reset the base register reads 0, the memory-space enable reads 0, and DEVSEL, TRDY and STOP are deasserted (high). The target claims no access until it has been configured.
- R2: A write to the base register keeps bits 31:16 and bit 0 (the ROM enable) and forces bits 15:1 to zero. The zero bits in 15:11 are what signal a 64 KB window.
- R3: An access inside the window is not claimed unless both the memory-space enable and the ROM enable are 1.
- R4: When enabled, a Memory Read (C/BE 0110) is claimed (DEVSEL low on the cycle after the address phase) if and only if AD[31:16] equals base bits 31:16. This covers base through base+0xFFFC; addresses outside the window are not claimed.
- R5: Memory Read Multiple (1100) and Memory Read Line (1110) are handled exactly like Memory Read, including timing and data.
- R6: A read fetches the ROM bytes at addresses {AD[15:2], k} for k = 0..3 and drives byte k on AD[8k+7:8k]. The result is the same for any data-phase byte enables, so 8-, 16- and 32-bit reads all find their lanes.
- R7: With timing field T, each byte takes T+1 clocks with the ROM output enable low. TRDY goes low at the edge 4·(T+1) clocks after the edge that samples the address phase.
- R8: If FRAME is still asserted when the first read data phase completes, the next cycle shows STOP low, TRDY high and DEVSEL low. This state holds until the transaction ends.
- R9: A write (C/BE 0111) is claimed with DEVSEL on the cycle after the address phase, with TRDY following one clock later. It alters neither ROM data read back nor the base register.
- R10: Once the master has ended the transaction (FRAME and IRDY both high after the last phase), DEVSEL, TRDY and STOP are all high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bar_we | input | 1 | Write strobe for the ROM base register |
| cfg_cmd_we | input | 1 | Write strobe for the command register (bit 1 = memory-space enable) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_bar_rd | output | 32 | ROM base register readback |
| cfg_mem_en_rd | output | 1 | Memory-space enable readback |
| frame_n | input | 1 | FRAME, active low |
| irdy_n | input | 1 | IRDY, active low |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase) |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | High while ad_out holds valid read data |
| devsel_n | output | 1 | DEVSEL, active low |
| trdy_n | output | 1 | TRDY, active low |
| stop_n | output | 1 | STOP, active low |
| rom_tmg | input | 4 | ROM wait clocks per byte minus one |
| rom_addr | output | 16 | Byte address to the ROM |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_data | input | 8 | ROM byte data |

## Verification
The hardest situation to reach is the disconnect path, because it needs the master to keep FRAME asserted across a read data phase that only completes after a long, timing-dependent fetch. The bench's read task takes a burst flag and holds FRAME low through the handshake. It then walks the master through the STOP response and the final release, under both directed and random timing values. The window edges are reached with directed addresses at base+0xFFFC, base+0x10000 and base−4. Random reads mix the three read commands, byte enables, window offsets and timing fields.

// File: rtl/optrom_pkg.sv
// Shared types for the option ROM target: controller states, bus command
// codes and the access classification used by the address decoder.
package optrom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RDATA,
        ST_DISC,
        ST_WCLAIM,
        ST_WDATA
    } tgt_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_kind_e;

    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

    // Fold every read flavour to a plain read; anything else is ignored.
    function automatic acc_kind_e classify_cmd(logic [3:0] cmd);
        acc_kind_e kind;
        case (cmd)
            CMD_MEM_RD, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE: kind = ACC_READ;
            CMD_MEM_WR:                                   kind = ACC_WRITE;
            default:                                      kind = ACC_NONE;
        endcase
        return kind;
    endfunction

endpackage

// File: rtl/optrom_cfg.sv
// Configuration state of the option ROM target: the ROM base register and
// the memory-space enable. Assumes the surrounding configuration logic
// issues one-cycle write strobes. The bits below the window size read as 0.
module optrom_cfg #(
    parameter int unsigned WIN_BITS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bar_we,
    input  logic        cmd_we,
    input  logic [31:0] wdata,
    output logic [31:0] bar_q,
    output logic        mem_en,
    output logic        rom_en
);

    localparam logic [31:0] BAR_MASK = ~((32'd1 << WIN_BITS) - 32'd1) | 32'd1;

    logic mem_en_q;

    // Register writes; reset leaves the target unconfigured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q    <= '0;
            mem_en_q <= 1'b0;
        end else begin
            if (bar_we) bar_q    <= wdata & BAR_MASK;
            if (cmd_we) mem_en_q <= wdata[1];
        end
    end

    assign mem_en = mem_en_q;
    assign rom_en = bar_q[0];

    assert_bar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bar_we) |-> $stable(bar_q));

endmodule

// File: rtl/optrom_decode.sv
// Address-phase decode. Compares the upper address bits with the base
// register and classifies the command. It is purely combinational and
// assumes the caller qualifies its outputs with a real address phase.
module optrom_decode #(
    parameter int unsigned WIN_BITS = 16,
    localparam int unsigned HI_W    = 32 - WIN_BITS
) (
    input  logic [HI_W-1:0] ad_hi,
    input  logic [HI_W-1:0] base_hi,
    input  logic [3:0]      cmd,
    input  logic            mem_en,
    input  logic            rom_en,
    output logic            claim_rd,
    output logic            claim_wr
);
    import optrom_pkg::*;

    logic      in_window;
    logic      enabled;
    acc_kind_e kind;

    // Window hit, enable gate and command class in one step.
    always_comb begin
        in_window = (ad_hi == base_hi);
        enabled   = mem_en & rom_en;
        kind      = classify_cmd(cmd);
        claim_rd  = in_window && enabled && (kind == ACC_READ);
        claim_wr  = in_window && enabled && (kind == ACC_WRITE);
    end

endmodule

// File: rtl/optrom_fetch.sv
// Byte-fetch sequencer and 32-bit holding register. On start it reads the
// four bytes of the addressed word from the ROM, each taking tmg+1 clocks.
// Assumes tmg is stable for the whole fetch and start only arrives when idle.
module optrom_fetch #(
    parameter int unsigned WIN_BITS = 16,
    parameter int unsigned TMG_W    = 4,
    localparam int unsigned NBYTES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WIN_BITS-1:0] start_addr,
    input  logic [TMG_W-1:0]    tmg,
    input  logic [7:0]          rom_data,
    output logic [WIN_BITS-1:0] rom_addr,
    output logic                rom_oe_n,
    output logic                last,
    output logic [31:0]         word
);

    logic                busy;
    logic [1:0]          idx;
    logic [TMG_W-1:0]    cnt;
    logic [WIN_BITS-1:0] base_q;
    logic [31:0]         word_q;

    // Step through the bytes, sampling each after its wait count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            cnt    <= '0;
            base_q <= '0;
            word_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            cnt    <= '0;
            base_q <= start_addr & ~WIN_BITS'(3);
        end else if (busy) begin
            if (cnt == tmg) begin
                word_q[{idx, 3'b000} +: 8] <= rom_data;
                cnt <= '0;
                if (idx == 2'(NBYTES - 1)) busy <= 1'b0;
                else                       idx  <= idx + 2'd1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign last     = busy && (idx == 2'(NBYTES - 1)) && (cnt == tmg);
    assign rom_addr = base_q | WIN_BITS'(idx);
    assign rom_oe_n = !busy;
    assign word     = word_q;

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (idx == $past(idx))) |-> $stable(rom_addr));

    assert_fetch_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> rom_oe_n);

endmodule

// File: rtl/optrom_target.sv
// PCI option ROM target. Decodes address phases, claims the enabled 64 KB
// window, answers reads from a byte-wide ROM through the fetch sequencer,
// disconnects bursts at their second data phase and accepts writes without
// effect. Assumes a well-formed PCI master on the bus side.
module optrom_target #(
    parameter int unsigned WIN_BITS = 16,
    parameter int unsigned TMG_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_bar_we,
    input  logic                cfg_cmd_we,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_bar_rd,
    output logic                cfg_mem_en_rd,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [3:0]          cbe_n,
    input  logic [31:0]         ad_in,
    output logic [31:0]         ad_out,
    output logic                ad_oe,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n,
    input  logic [TMG_W-1:0]    rom_tmg,
    output logic [WIN_BITS-1:0] rom_addr,
    output logic                rom_oe_n,
    input  logic [7:0]          rom_data
);
    import optrom_pkg::*;

    localparam int unsigned HI_W = 32 - WIN_BITS;

    tgt_state_e st_q, st_d;
    logic       frame_q;
    logic       addr_phase;
    logic       mem_en, rom_en;
    logic       claim_rd, claim_wr;
    logic       fetch_start, fetch_last;
    logic [31:0] bar_q, word;

    optrom_cfg #(.WIN_BITS(WIN_BITS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .bar_we (cfg_bar_we),
        .cmd_we (cfg_cmd_we),
        .wdata  (cfg_wdata),
        .bar_q  (bar_q),
        .mem_en (mem_en),
        .rom_en (rom_en)
    );

    optrom_decode #(.WIN_BITS(WIN_BITS)) u_dec (
        .ad_hi    (ad_in[31:WIN_BITS]),
        .base_hi  (bar_q[31:WIN_BITS]),
        .cmd      (cbe_n),
        .mem_en   (mem_en),
        .rom_en   (rom_en),
        .claim_rd (claim_rd),
        .claim_wr (claim_wr)
    );

    optrom_fetch #(.WIN_BITS(WIN_BITS), .TMG_W(TMG_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .start_addr (ad_in[WIN_BITS-1:0]),
        .tmg        (rom_tmg),
        .rom_data   (rom_data),
        .rom_addr   (rom_addr),
        .rom_oe_n   (rom_oe_n),
        .last       (fetch_last),
        .word       (word)
    );

    // An address phase is the first cycle with FRAME asserted.
    assign addr_phase  = !frame_n && frame_q;
    assign fetch_start = (st_q == ST_IDLE) && addr_phase && claim_rd;

    // Next-state logic for the bus-side controller.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (addr_phase && claim_rd)      st_d = ST_FETCH;
                else if (addr_phase && claim_wr) st_d = ST_WCLAIM;
            end
            ST_FETCH:  if (fetch_last) st_d = ST_RDATA;
            ST_RDATA:  if (!irdy_n)    st_d = frame_n ? ST_IDLE : ST_DISC;
            ST_DISC:   if (frame_n && irdy_n) st_d = ST_IDLE;
            ST_WCLAIM: st_d = ST_WDATA;
            ST_WDATA:  if (!irdy_n && frame_n) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State and previous-FRAME registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            frame_q <= 1'b1;
        end else begin
            st_q    <= st_d;
            frame_q <= frame_n;
        end
    end

    assign devsel_n      = (st_q == ST_IDLE);
    assign trdy_n        = !((st_q == ST_RDATA) || (st_q == ST_WDATA));
    assign stop_n        = (st_q != ST_DISC);
    assign ad_oe         = (st_q == ST_RDATA);
    assign ad_out        = word;
    assign cfg_bar_rd    = bar_q;
    assign cfg_mem_en_rd = mem_en;

    assert_trdy_devsel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    assert_stop_trdy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!stop_n && !trdy_n));

    assert_no_claim_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && addr_phase && !(mem_en && rom_en)) |=> devsel_n);

    assert_burst_disc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RDATA) && !irdy_n && !frame_n) |=> (!stop_n && trdy_n && !devsel_n));

    assert_wr_trdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && addr_phase && claim_wr) |=> (!devsel_n && trdy_n) ##1 !trdy_n);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DISC) && frame_n && irdy_n) |=> (devsel_n && trdy_n && stop_n));

    assert_read_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_FETCH) && fetch_last) |=> (!trdy_n && ad_oe));

endmodule

// File: tb/optrom_target_tb.sv
// Self-checking bench for optrom_target: directed corner cases plus
// seeded random reads, checked against a bench model of the ROM and window.
module optrom_target_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_bar_we, cfg_cmd_we;
    logic [31:0] cfg_wdata, cfg_bar_rd;
    logic        cfg_mem_en_rd;
    logic        frame_n, irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in, ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n;
    logic [3:0]  rom_tmg;
    logic [15:0] rom_addr;
    logic        rom_oe_n;
    logic [7:0]  rom_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Bench model of configuration state.
    logic [15:0] m_base = 16'h0;
    bit          m_mem_en = 0;
    bit          m_rom_en = 0;

    always #4 clk = ~clk;

    optrom_target u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_bar_we(cfg_bar_we), .cfg_cmd_we(cfg_cmd_we), .cfg_wdata(cfg_wdata),
        .cfg_bar_rd(cfg_bar_rd), .cfg_mem_en_rd(cfg_mem_en_rd),
        .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .rom_tmg(rom_tmg), .rom_addr(rom_addr),
        .rom_oe_n(rom_oe_n), .rom_data(rom_data)
    );

    function automatic logic [7:0] rom_byte(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [31:0] rom_word(logic [15:0] a);
        logic [15:0] w = {a[15:2], 2'b00};
        return {rom_byte(w | 16'd3), rom_byte(w | 16'd2),
                rom_byte(w | 16'd1), rom_byte(w)};
    endfunction

    assign rom_data = rom_oe_n ? 8'hzz : rom_byte(rom_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_bar(input logic [31:0] v);
        @(negedge clk);
        cfg_bar_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_bar_we = 1'b0;
        m_base = v[31:16]; m_rom_en = v[0];
    endtask

    task automatic write_cmd(input bit en);
        @(negedge clk);
        cfg_cmd_we = 1'b1; cfg_wdata = {30'h0, en, 1'b0};
        @(negedge clk);
        cfg_cmd_we = 1'b0;
        m_mem_en = en;
    endtask

    task automatic do_read(input logic [31:0] addr, input logic [3:0] cmd,
                           input logic [3:0] be, input bit burst,
                           input logic [3:0] tmg, input string req);
        bit exp_claim;
        int n;
        rom_tmg = tmg;
        @(negedge clk);
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd; irdy_n = 1'b1;
        @(negedge clk);
        exp_claim = m_mem_en && m_rom_en && (addr[31:16] == m_base);
        check({req, " claim"}, {31'h0, devsel_n}, {31'h0, !exp_claim});
        if (!exp_claim) begin
            // Master abort path: last phase, then release.
            frame_n = 1'b1; irdy_n = 1'b0;
            repeat (3) @(negedge clk);
            check({req, " ignored"}, {29'h0, devsel_n, trdy_n, stop_n}, 32'h7);
            irdy_n = 1'b1;
            @(negedge clk);
            return;
        end
        ad_in = $urandom; cbe_n = be; irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1;
        // R6: first ROM byte address, output enable active (R7).
        check("R6 rom addr", {15'h0, rom_oe_n, rom_addr}, {16'h0, addr[15:2], 2'b00});
        n = 1;
        while (trdy_n && n < 400) begin
            @(negedge clk);
            n++;
        end
        check({req, " R7 latency"}, n, 4 * (int'(tmg) + 1) + 1);
        check({req, " R6 data"}, ad_out, rom_word(addr[15:0]));
        check("R6 oe", {31'h0, ad_oe}, 32'h1);
        @(negedge clk);
        if (!burst) begin
            irdy_n = 1'b1;
            check("R10 end single", {29'h0, devsel_n, trdy_n, stop_n}, 32'h7);
        end else begin
            check("R8 disconnect", {29'h0, devsel_n, trdy_n, stop_n}, 32'h2);
            frame_n = 1'b1;
            @(negedge clk);
            check("R8 stop held", {29'h0, devsel_n, trdy_n, stop_n}, 32'h2);
            irdy_n = 1'b1;
            @(negedge clk);
            check("R10 end burst", {29'h0, devsel_n, trdy_n, stop_n}, 32'h7);
        end
    endtask

    task automatic do_write(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        frame_n = 1'b0; ad_in = addr; cbe_n = 4'b0111; irdy_n = 1'b1;
        @(negedge clk);
        check("R9 write claim", {30'h0, devsel_n, trdy_n}, 32'h1);
        ad_in = data; cbe_n = 4'b0000; irdy_n = 1'b0; frame_n = 1'b1;
        @(negedge clk);
        check("R9 write trdy", {30'h0, devsel_n, trdy_n}, 32'h0);
        @(negedge clk);
        irdy_n = 1'b1;
        check("R10 write end", {29'h0, devsel_n, trdy_n, stop_n}, 32'h7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] rcmds [3] = '{4'b0110, 4'b1100, 4'b1110};
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_bar_we = 0; cfg_cmd_we = 0; cfg_wdata = '0;
        frame_n = 1; irdy_n = 1; cbe_n = 4'hF; ad_in = '0; rom_tmg = 4'd0;
        repeat (5) @(negedge clk);
        // R1 reset state.
        check("R1 bar", cfg_bar_rd, 32'h0);
        check("R1 mem_en", {31'h0, cfg_mem_en_rd}, 32'h0);
        check("R1 outputs", {29'h0, devsel_n, trdy_n, stop_n}, 32'h7);
        rst_n = 1'b1;
        do_read(32'h0000_0010, 4'b0110, 4'h0, 0, 4'd0, "R1 unconfigured");

        // R2 base register fields.
        write_bar(32'hABCD_FFFF);
        check("R2 bar readback", cfg_bar_rd, 32'hABCD_0001);
        // R3 enable combinations.
        do_read(32'hABCD_0100, 4'b0110, 4'h0, 0, 4'd1, "R3 mem_en off");
        write_cmd(1);
        check("R1 mem_en set", {31'h0, cfg_mem_en_rd}, 32'h1);
        write_bar(32'hABCD_0000);
        do_read(32'hABCD_0100, 4'b0110, 4'h0, 0, 4'd1, "R3 rom_en off");
        write_bar(32'hABCD_0001);

        // R4 window edges, R7 timing extremes.
        do_read(32'hABCD_0000, 4'b0110, 4'h0, 0, 4'd0, "R4 base");
        do_read(32'hABCD_FFFC, 4'b0110, 4'h0, 0, 4'd15, "R4 top");
        do_read(32'hABCE_0000, 4'b0110, 4'h0, 0, 4'd2, "R4 above");
        do_read(32'hABCC_FFFC, 4'b0110, 4'h0, 0, 4'd2, "R4 below");
        // R5 aliased read commands.
        do_read(32'hABCD_1234, 4'b1100, 4'h0, 0, 4'd3, "R5 multiple");
        do_read(32'hABCD_1234, 4'b1110, 4'h0, 0, 4'd3, "R5 line");
        // R6 narrow reads.
        do_read(32'hABCD_2201, 4'b0110, 4'b1110, 0, 4'd1, "R6 byte");
        do_read(32'hABCD_2202, 4'b0110, 4'b0011, 0, 4'd1, "R6 half");
        // R8 burst disconnect.
        do_read(32'hABCD_4000, 4'b1110, 4'h0, 1, 4'd4, "R8 burst");
        // R9 writes have no effect.
        do_write(32'hABCD_5550, 32'hDEAD_BEEF);
        check("R9 bar unchanged", cfg_bar_rd, 32'hABCD_0001);
        do_read(32'hABCD_5550, 4'b0110, 4'h0, 0, 4'd2, "R9 readback");

        // Random mix.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            a = {($urandom_range(0, 3) == 0) ? 16'($urandom) : m_base, 16'($urandom)};
            do_read(a, rcmds[$urandom_range(0, 2)], 4'($urandom),
                    1'($urandom), 4'($urandom), "R4 R5 R6 R7 random");
        end
        // Move the window and repeat a boundary read.
        write_bar(32'h0042_0001);
        do_read(32'h0042_FFFC, 4'b0110, 4'h0, 1, 4'd7, "R4 moved");
        do_read(32'hABCD_0000, 4'b0110, 4'h0, 0, 4'd0, "R4 old window");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule